// File: doc/BRIEF.md
# Slow-Clock Wrapping Counter with Compare Event

This block is a free-running counter advanced by a low-frequency tick enable. The tick enable is sampled in the fast system clock domain. A programmable prescaler divides the tick rate, and the count wraps modulo 2^CNT_W (24 bits by default). A single compare register is armed by a host write. When the count steps onto the stored compare value, a sticky event flag is raised. The flag drives an interrupt output through an enable bit.

The block reproduces the arming rule of slow compare hardware. A compare value written two or more counts ahead of the live count is certain to fire. A value written exactly one count ahead is missed on that pass. A value equal to the live count, or already behind it, fires only after the count wraps back around to it. Software uses the two strobe inputs to clear and start the counter. It uses a simple write/read strobe interface to program the compare value, the divider and the interrupt enable, to read the live count and to acknowledge the event.

Register selector values on `addr`: 0 = live count (read only), 1 = compare value, 2 = prescaler divider, 3 = interrupt enable (bit 0), 4 = event flag (bit 0). Other selector values read as zero.

Top module: `rtc_cmp_counter`

## Requirements
- R1: After reset the counter is stopped, and the count, compare value, divider, interrupt enable, event flag and `irq` all read zero.
- R2: The count does not move until a `task_start` pulse. A `task_clear` pulse sets the count to zero in the next cycle. When both strobes arrive in the same cycle, the count is zero afterwards and counting then proceeds from zero.
- R3: With divider value P, the count advances by one on every (P+1)-th `lf_tick` cycle counted from the last clear. With P = 0 it advances on every `lf_tick` cycle.
- R4: The count wraps from 2^CNT_W−1 to 0. All distances between counts are taken modulo 2^CNT_W.
- R5: A write to selector 1 keeps only the low CNT_W bits of `wr_data`, and reading selector 1 returns that masked value.
- R6: A compare match happens only on an increment that makes the count equal to the compare value. The event flag reads 1 in the same cycle that the count first shows that value.
- R7: A compare value written when it is two or more counts ahead of the live count (modulo 2^CNT_W) always raises the event when the count reaches it.
- R8: A compare value written exactly one count ahead of the live count raises no event when the count reaches it on that pass. It does fire one full wrap later.
- R9: A compare value equal to the live count, or behind it, raises no event until the count wraps around to that value.
- R10: The event flag stays set until a write of all-zero data to selector 4. A nonzero write to selector 4 leaves the flag unchanged.
- R11: `irq` is 1 exactly while the event flag and the interrupt enable (selector 3, bit 0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | One-cycle enable marking a low-frequency clock tick |
| task_clear | input | 1 | Strobe: zero the count and the prescaler phase |
| task_start | input | 1 | Strobe: let the counter run |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register selector for reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, zero-extended |
| irq | output | 1 | Compare interrupt |

## Verification
The near miss is the hardest case to reach. A compare write has to land exactly one count ahead of the live count, and the bench then has to show that the miss is only for that pass. The bench drives `lf_tick` itself, so it knows the live count at the moment of each write. It writes count+1 and then steps the count through the value. To see the recovery, a second instance with an 8-bit counter receives the same stimulus, and 256 further ticks carry it through a complete wrap back onto the compare value. The same narrow instance brings the wrap itself within reach.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    SEL_COUNT = 3'd0,
    SEL_CMP   = 3'd1,
    SEL_PRESC = 3'd2,
    SEL_IRQEN = 3'd3,
    SEL_EVENT = 3'd4
  } reg_sel_e;

  // mask covering the low w bits of a 32-bit word
  function automatic logic [31:0] ring_mask(input int unsigned w);
    if (w >= 32) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

  // forward distance from b to a on a ring of 2^w counts
  function automatic logic [31:0] ring_gap(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input int unsigned w);
    return (a - b) & ring_mask(w);
  endfunction

  // successor of a on a ring of 2^w counts
  function automatic logic [31:0] ring_next(input logic [31:0] a,
                                            input int unsigned w);
    return (a + 32'd1) & ring_mask(w);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             lf_tick,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] phase_q;
  logic             active;

  assign active = run & lf_tick & ~restart;
  // >= so that lowering the divider mid-phase cannot strand the phase
  assign step   = active && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (active)  phase_q <= step ? '0 : phase_q + 1'b1;
  end

  // R3
  prescale_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && div == '0) |-> step);
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_task,
  input  logic             start_task,
  input  logic             step,
  output logic             run,
  output logic [CNT_W-1:0] count,
  output logic             inc_evt
);
  import rtc_pkg::*;

  logic             run_q;
  logic [CNT_W-1:0] count_q;

  assign run     = run_q;
  assign count   = count_q;
  assign inc_evt = step;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= 1'b0;
    else if (start_task) run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        count_q <= '0;
    else if (clr_task) count_q <= '0;
    else if (step)     count_q <= count_q + 1'b1;
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_task |=> count_q == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_task) |=> $stable(count_q));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_task |=> (count_q == $past(count_q)) ||
                  (ring_gap(32'(count_q), 32'($past(count_q)), CNT_W) == 32'd1));
endmodule

// File: rtl/rtc_compare_unit.sv
module rtc_compare_unit #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             inc_evt,
  input  logic             clr_task,
  input  logic             evt_clr,
  output logic [CNT_W-1:0] cmp_val,
  output logic             evt_flag,
  output logic             hit,
  output logic             near_miss
);
  import rtc_pkg::*;

  logic [CNT_W-1:0] cmp_q;
  logic             skip_q;
  logic             evt_q;
  logic [31:0]      write_gap;

  // distance from the live count to the value being written
  assign write_gap = ring_gap(32'(cmp_wdata), 32'(count), CNT_W);
  assign near_miss = cmp_we && (write_gap == 32'd1);
  assign hit       = inc_evt && !skip_q &&
                     (ring_next(32'(count), CNT_W) == 32'(cmp_q));
  assign cmp_val   = cmp_q;
  assign evt_flag  = evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  // a one-ahead write masks the very next increment only
  always_ff @(posedge clk) begin
    if (!rst_n)         skip_q <= 1'b0;
    else if (clr_task)  skip_q <= 1'b0;
    else if (near_miss) skip_q <= 1'b1;
    else if (inc_evt)   skip_q <= 1'b0;
  end

  // a match wins over a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (hit)     evt_q <= 1'b1;
    else if (evt_clr) evt_q <= 1'b0;
  end

  // R5
  cmp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> cmp_q == $past(cmp_wdata));

  // R6
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_q);

  // R8
  near_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (near_miss && !clr_task) |=> !hit);

  // R10
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !evt_clr) |=> evt_q);
endmodule

// File: rtl/rtc_cmp_counter.sv
module rtc_cmp_counter #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic              task_clear,
  input  logic              task_start,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import rtc_pkg::*;

  logic [PRE_W-1:0] presc_q;
  logic             irq_en_q;
  logic             run, step, inc_evt, hit, near_miss, evt_flag;
  logic [CNT_W-1:0] count, cmp_val;
  logic             cmp_we, presc_we, irqen_we, evt_clr;
  reg_sel_e         sel;

  assign sel      = reg_sel_e'(addr);
  assign cmp_we   = wr_en && (sel == SEL_CMP);
  assign presc_we = wr_en && (sel == SEL_PRESC);
  assign irqen_we = wr_en && (sel == SEL_IRQEN);
  assign evt_clr  = wr_en && (sel == SEL_EVENT) && (wr_data == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q  <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (presc_we) presc_q  <= wr_data[PRE_W-1:0];
      if (irqen_we) irq_en_q <= wr_data[0];
    end
  end

  rtc_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (task_clear),
    .lf_tick (lf_tick),
    .div     (presc_q),
    .step    (step)
  );

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_task   (task_clear),
    .start_task (task_start),
    .step       (step),
    .run        (run),
    .count      (count),
    .inc_evt    (inc_evt)
  );

  rtc_compare_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_we    (cmp_we),
    .cmp_wdata (wr_data[CNT_W-1:0]),
    .count     (count),
    .inc_evt   (inc_evt),
    .clr_task  (task_clear),
    .evt_clr   (evt_clr),
    .cmp_val   (cmp_val),
    .evt_flag  (evt_flag),
    .hit       (hit),
    .near_miss (near_miss)
  );

  assign irq = evt_flag & irq_en_q;

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_COUNT: rd_data = DATA_W'(count);
      SEL_CMP:   rd_data = DATA_W'(cmp_val);
      SEL_PRESC: rd_data = DATA_W'(presc_q);
      SEL_IRQEN: rd_data = DATA_W'(irq_en_q);
      SEL_EVENT: rd_data = DATA_W'(evt_flag);
      default:   rd_data = '0;
    endcase
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && irq_en_q && !irqen_we) |=> irq);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en_q && !irqen_we) |=> !irq);
endmodule

// File: tb/rtc_cmp_counter_tb_top.sv
module rtc_cmp_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_tick = 1'b0;
  logic        task_clear = 1'b0;
  logic        task_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_w;
  logic        irq, irq_w;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rtc_cmp_counter dut_i (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .task_clear(task_clear),
    .task_start(task_start), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq));

  // narrow twin for wrap scenarios
  rtc_cmp_counter #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .task_clear(task_clear),
    .task_start(task_start), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data_w), .irq(irq_w));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic adv(input int n);
    lf_tick = 1'b1;
    for (int k = 0; k < n; k++) cyc();
    lf_tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v, output logic [31:0] vw);
    addr = a; #1;
    v = rd_data; vw = rd_data_w;
  endtask

  task automatic pulse(input bit clr, input bit st);
    task_clear = clr; task_start = st;
    cyc();
    task_clear = 1'b0; task_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v, vw;
    for (int a = 0; a < 5; a++) begin
      peek(3'(a), v, vw);
      chk("R1 register zero after reset", v, 32'd0);
    end
    chk("R1 irq low after reset", 32'(irq), 32'd0);
    adv(3);
    peek(3'd0, v, vw);
    chk("R2 no counting before start", v, 32'd0);
  endtask

  task automatic t_start_clear();
    logic [31:0] v, vw;
    pulse(1'b0, 1'b1);
    adv(5);
    peek(3'd0, v, vw);
    chk("R3 divider zero counts every tick", v, 32'd5);
    pulse(1'b1, 1'b0);
    peek(3'd0, v, vw);
    chk("R2 clear zeroes count", v, 32'd0);
    adv(2);
    pulse(1'b1, 1'b1);
    peek(3'd0, v, vw);
    chk("R2 clear wins over start", v, 32'd0);
    adv(3);
    peek(3'd0, v, vw);
    chk("R2 counting resumes from zero", v, 32'd3);
  endtask

  task automatic t_prescale();
    logic [31:0] v, vw;
    wr(3'd2, 32'd3);
    pulse(1'b1, 1'b0);
    adv(8);
    peek(3'd0, v, vw);
    chk("R3 divide by four after 8 ticks", v, 32'd2);
    adv(3);
    peek(3'd0, v, vw);
    chk("R3 holds mid phase", v, 32'd2);
    adv(1);
    peek(3'd0, v, vw);
    chk("R3 steps on fourth tick", v, 32'd3);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] v, vw;
    wr(3'd1, 32'hABCD_EF12);
    peek(3'd1, v, vw);
    chk("R5 compare masked to 24 bits", v, 32'h00CD_EF12);
    chk("R5 compare masked to 8 bits", vw, 32'h0000_0012);
  endtask

  task automatic t_match();
    logic [31:0] v, vw;
    pulse(1'b1, 1'b0);
    wr(3'd1, 32'd5);
    wr(3'd3, 32'd1);
    adv(4);
    peek(3'd4, v, vw);
    chk("R6 no event before match", v, 32'd0);
    chk("R11 irq low before match", 32'(irq), 32'd0);
    adv(1);
    peek(3'd0, v, vw);
    chk("R6 count at compare value", v, 32'd5);
    peek(3'd4, v, vw);
    chk("R7 event with compare 5 ahead", v, 32'd1);
    chk("R11 irq with event and enable", 32'(irq), 32'd1);
    adv(1);
    peek(3'd4, v, vw);
    chk("R10 event sticky past match", v, 32'd1);
    wr(3'd4, 32'd1);
    peek(3'd4, v, vw);
    chk("R10 nonzero write ignored", v, 32'd1);
    wr(3'd4, 32'd0);
    peek(3'd4, v, vw);
    chk("R10 zero write clears", v, 32'd0);
    chk("R11 irq drops with event", 32'(irq), 32'd0);
    // count is 6: exactly two ahead
    wr(3'd1, 32'd8);
    adv(1);
    peek(3'd4, v, vw);
    chk("R7 no event one short", v, 32'd0);
    adv(1);
    peek(3'd4, v, vw);
    chk("R7 event with compare 2 ahead", v, 32'd1);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_near_miss();
    logic [31:0] v, vw;
    // count is 8 in both instances
    wr(3'd1, 32'd9);
    adv(1);
    peek(3'd0, v, vw);
    chk("R8 count reached near value", v, 32'd9);
    peek(3'd4, v, vw);
    chk("R8 no event on near miss", v, 32'd0);
    chk("R8 no event on near miss narrow", vw, 32'd0);
    adv(255);
    peek(3'd4, v, vw);
    chk("R8 narrow not yet back", vw, 32'd0);
    peek(3'd0, v, vw);
    chk("R4 narrow count wrapped", vw, 32'd8);
    adv(1);
    peek(3'd4, v, vw);
    chk("R8 event one wrap later", vw, 32'd1);
    chk("R8 wide instance no event", v, 32'd0);
    chk("R11 narrow irq", 32'(irq_w), 32'd1);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_behind();
    logic [31:0] v, vw;
    // wide count 265, narrow count 9
    wr(3'd1, 32'd265);
    adv(1);
    peek(3'd4, v, vw);
    chk("R9 equal value no event", v, 32'd0);
    chk("R9 equal value no event narrow", vw, 32'd0);
    wr(3'd1, 32'd256);
    adv(10);
    peek(3'd4, v, vw);
    chk("R9 past value no event", v, 32'd0);
  endtask

  task automatic t_irq_gate();
    logic [31:0] v, vw;
    wr(3'd3, 32'd0);
    pulse(1'b1, 1'b0);
    wr(3'd1, 32'd3);
    adv(3);
    peek(3'd4, v, vw);
    chk("R6 event at compare 3", v, 32'd1);
    chk("R11 irq masked by enable", 32'(irq), 32'd0);
    wr(3'd3, 32'd1);
    chk("R11 irq after enable", 32'(irq), 32'd1);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] v, vw;
    pulse(1'b1, 1'b0);
    adv(255);
    peek(3'd0, v, vw);
    chk("R4 narrow at top value", vw, 32'd255);
    adv(1);
    peek(3'd0, v, vw);
    chk("R4 narrow wraps to zero", vw, 32'd0);
    chk("R4 wide keeps counting", v, 32'd256);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_start_clear();
    t_prescale();
    t_mask();
    t_match();
    t_near_miss();
    t_behind();
    t_irq_gate();
    t_wrap();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule